// File: doc/BRIEF.md
# Configurable Registered/Combinational I/O Macrocell

This block is the output cell that sits behind one sum-of-products in a programmable logic array. It receives the OR-sum of its product terms, its own output-enable term, the shared preset and clear terms, and two candidate register clocks: one from a pin and one built from a product term. From these it produces the value that drives the pin, the tri-state enable for that pin, and the signal fed back into the array.

A four-bit mode word sets three things. Bit 3 selects the polarity. Bit 2 selects a registered or a combinational output. Bits 2 to 0 together pick the feedback: the pin, the raw OR-sum, or the register Q. Two further bits pick which clock drives the register and whether that clock is inverted. The register and every output run in one system clock domain. The chosen register clock is sampled on each system edge, and the register loads when that sampled clock makes an active transition. The clear term masks Q straight away, with no edge needed. The preset acts only on an active register-clock edge.

Top module: `mc_iocell`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, the register is set to 0. After reset, with mode 4'b1000, `pin_out` and `fb_out` both read 0.
- R2: The register loads `or_sum` at the system edge where the selected register clock, after optional inversion, is first seen high after having been seen low. No other edge changes it.
- R3: With `cfg_clk_pterm` at 0 the register clock is `pin_clk`, and with it at 1 the clock is `pt_clk`. Transitions on the clock that is not selected leave the register unchanged.
- R4: With `cfg_clk_inv` at 1 the register loads on a high-to-low transition of the chosen source. A low-to-high transition of that source does not load it.
- R5: If `preset_term` is high at an active register-clock edge and `clear_term` is low, the register becomes 1 whatever `or_sum` is.
- R6: While `clear_term` is high, Q reads 0 in the same cycle with no clock edge needed. Once clear has been high for at least one `clk` edge, Q stays 0 after clear falls, until the next active edge.
- R7: When `clear_term` and `preset_term` are both high at an active edge, the register ends at 0.
- R8: Mode bit 2 (B) chooses the output source. B=0 drives the register Q and B=1 drives `or_sum`, for the legal codes (bits 2..0 in {000,010,011,100,110,111}).
- R9: Mode bit 3 (A) sets polarity. With A=1 `pin_out` equals the chosen source, and with A=0 it is the inverse.
- R10: Feedback is chosen by bits 2..0. Codes 010 and 100 return `pin_in`, codes 011 and 111 return `or_sum`, and codes 000 and 110 return Q. This holds whether the output is registered or combinational.
- R11: For legal codes `pin_oe` equals `oe_term`. A term held at 1 gives a dedicated output, and a term held at 0 gives an input-only pin whose feedback still follows the mode.
- R12: Codes with bits 2..0 equal to 001 or 101 make the pin input-only: `pin_oe`=0, `pin_out`=0 and `fb_out`=`pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 4 | Mode word {A,B,C,D}: polarity, output source, feedback source |
| cfg_clk_pterm | input | 1 | 0: register clock from pin_clk, 1: from pt_clk |
| cfg_clk_inv | input | 1 | 1 inverts the selected register clock |
| or_sum | input | 1 | OR of this cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Shared synchronous preset term |
| clear_term | input | 1 | Shared asynchronous clear term |
| pin_clk | input | 1 | Register clock from the dedicated pin |
| pt_clk | input | 1 | Register clock formed by a product term |
| pin_in | input | 1 | Value seen on the I/O pin |
| pin_out | output | 1 | Value driven onto the pin when enabled |
| pin_oe | output | 1 | Tri-state enable for the pin |
| fb_out | output | 1 | Feedback returned to the array |

## Verification
The properties assume that the register clocks and the configuration change only between system clock edges. They also assume that a configuration change never turns an idle clock level into an apparent active transition. The stimulus meets this by setting the polarity bit and the idle source levels together on the same falling system edge. The properties further take for granted that a clear pulse covers at least one system edge. The bench holds each clear for a full cycle before releasing it. Every combination of the 16 mode codes with the enable, sum and pin levels is swept once with Q at 0 and once with Q at 1.

// File: rtl/mc_pkg.sv
// Package for the I/O macrocell.
// Holds the mode-word width, the feedback-source encoding, the decoded
// configuration record and the function that maps a mode word onto that
// record. Assumes the mode word is ordered {A,B,C,D} with A as the MSB.
package mc_pkg;

    localparam int MODE_W = 4;
    localparam int POL_BIT = MODE_W - 1;
    localparam int SRC_BIT = MODE_W - 2;
    localparam int SEL_W = MODE_W - 1;

    typedef enum logic [1:0] {
        FB_REG = 2'd0,
        FB_PIN = 2'd1,
        FB_SUM = 2'd2,
        FB_OFF = 2'd3
    } fb_src_e;

    typedef struct packed {
        logic    legal;
        logic    active_high;
        logic    registered;
        fb_src_e fb_src;
    } cell_cfg_t;

    // Map a mode word onto polarity, output source and feedback source.
    function automatic cell_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        cell_cfg_t c;
        c.active_high = m[POL_BIT];
        c.registered  = ~m[SRC_BIT];
        c.legal       = 1'b1;
        case (m[SEL_W-1:0])
            3'b010, 3'b100: c.fb_src = FB_PIN;
            3'b011, 3'b111: c.fb_src = FB_SUM;
            3'b000, 3'b110: c.fb_src = FB_REG;
            default: begin
                c.fb_src = FB_OFF;
                c.legal  = 1'b0;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mc_cfg_decode.sv
// Mode decoder.
// Turns the raw mode word into the configuration record used by the output
// and feedback multiplexers. Purely combinational; assumes the mode word is
// quasi-static and changes only between system clock edges.
module mc_cfg_decode
    import mc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output cell_cfg_t         cfg
);

    // Apply the shared decode function to the mode word.
    always_comb begin
        cfg = decode_mode(mode);
    end

endmodule

// File: rtl/mc_clk_select.sv
// Register clock selector.
// Picks the pin clock or the product-term clock, applies the programmed
// inversion, and emits a one-cycle tick when the result is seen rising at a
// system clock edge. Assumes both candidate clocks are slow compared with
// clk and change only between system edges. The history flop resets to
// IDLE_PREV so that a level that is already active at reset release does
// not count as an edge.
module mc_clk_select #(
    parameter bit IDLE_PREV = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_clk,
    input  logic pt_clk,
    input  logic use_pterm,
    input  logic invert,
    output logic tick
);

    logic chosen;
    logic level_now;
    logic level_prev;

    // Choose the source and apply polarity.
    always_comb begin
        chosen    = use_pterm ? pt_clk : pin_clk;
        level_now = chosen ^ invert;
    end

    // Remember the level seen at the previous system edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_prev <= IDLE_PREV;
        end else begin
            level_prev <= level_now;
        end
    end

    // Flag a low-to-high transition of the polarity-corrected clock.
    always_comb begin
        tick = level_now & ~level_prev;
    end

endmodule

// File: rtl/mc_dff.sv
// Macrocell D register with preset and clear.
// Loads the data input on each clock tick. A preset seen on a tick forces
// the register to 1. Clear masks the output at once and clears the stored
// bit on every system edge it covers, so clear overrides preset. Assumes
// clear is held for at least one system edge when the stored bit must
// stay cleared after clear is released.
module mc_dff (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic d,
    input  logic preset,
    input  logic clear,
    output logic q,
    output logic q_hold
);

    // Next state: clear first, then preset on a tick, then data on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_hold <= 1'b0;
        end else if (clear) begin
            q_hold <= 1'b0;
        end else if (tick) begin
            q_hold <= preset ? 1'b1 : d;
        end
    end

    // Clear takes effect without waiting for any edge.
    always_comb begin
        q = clear ? 1'b0 : q_hold;
    end

endmodule

// File: rtl/mc_out_mux.sv
// Output and feedback multiplexers.
// Chooses the register or the OR-sum for the pin, applies polarity, gates
// the tri-state enable with the enable term, and routes the pin, the sum
// or Q back to the array. An illegal mode makes the pin input-only.
// Assumes cfg is already decoded.
module mc_out_mux
    import mc_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      q,
    input  logic      sum,
    input  logic      pin_in,
    input  logic      oe_term,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      fb_out
);

    logic pre_pol;

    // Drive side: pick the source, apply polarity, silence illegal modes.
    always_comb begin
        pre_pol = cfg.registered ? q : sum;
        if (cfg.legal) begin
            pin_out = cfg.active_high ? pre_pol : ~pre_pol;
        end else begin
            pin_out = 1'b0;
        end
        pin_oe = cfg.legal & oe_term;
    end

    // Feedback side: pick what goes back into the array.
    always_comb begin
        case (cfg.fb_src)
            FB_REG:  fb_out = q;
            FB_SUM:  fb_out = sum;
            FB_PIN:  fb_out = pin_in;
            default: fb_out = pin_in;
        endcase
    end

endmodule

// File: rtl/mc_iocell.sv
// Configurable I/O macrocell, top level.
// Ties together the mode decoder, the register clock selector, the D
// register and the output/feedback multiplexers. Everything is clocked by
// clk. The register clocks are sampled as data. Reset is synchronous and
// active low.
module mc_iocell
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_clk_pterm,
    input  logic              cfg_clk_inv,
    input  logic              or_sum,
    input  logic              oe_term,
    input  logic              preset_term,
    input  logic              clear_term,
    input  logic              pin_clk,
    input  logic              pt_clk,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_out
);

    cell_cfg_t cell_cfg;
    logic      sel_tick;
    logic      q_eff;
    logic      q_hold;

    mc_cfg_decode u_dec (
        .mode (cfg_mode),
        .cfg  (cell_cfg)
    );

    mc_clk_select #(
        .IDLE_PREV (1'b1)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_clk   (pin_clk),
        .pt_clk    (pt_clk),
        .use_pterm (cfg_clk_pterm),
        .invert    (cfg_clk_inv),
        .tick      (sel_tick)
    );

    mc_dff u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sel_tick),
        .d      (or_sum),
        .preset (preset_term),
        .clear  (clear_term),
        .q      (q_eff),
        .q_hold (q_hold)
    );

    mc_out_mux u_mux (
        .cfg     (cell_cfg),
        .q       (q_eff),
        .sum     (or_sum),
        .pin_in  (pin_in),
        .oe_term (oe_term),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb_out  (fb_out)
    );

endmodule

// File: rtl/mc_iocell_chk.sv
// Property checker for the I/O macrocell, bound to every mc_iocell.
// Observes the ports together with the clock tick and the stored register
// bit. Assumes inputs change only between system clock edges.
module mc_iocell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cfg_mode,
    input logic       or_sum,
    input logic       oe_term,
    input logic       preset_term,
    input logic       clear_term,
    input logic       pin_in,
    input logic       pin_oe,
    input logic       fb_out,
    input logic       tick,
    input logic       q_hold
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> !q_hold);

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear_term) |=> $stable(q_hold));

    // R5
    preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && preset_term && !clear_term) |=> q_hold);

    // R6
    clear_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_term && cfg_mode[2:0] == 3'b000) |-> !fb_out);

    // R6
    clear_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_term |=> !q_hold);

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && preset_term && clear_term) |=> !q_hold);

    // R10
    sum_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1:0] == 2'b11) |-> (fb_out == or_sum));

    // R11
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_term |-> !pin_oe);

    // R12
    illegal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1:0] == 2'b01) |-> (!pin_oe && fb_out == pin_in));

endmodule

bind mc_iocell mc_iocell_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .or_sum      (or_sum),
    .oe_term     (oe_term),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .pin_in      (pin_in),
    .pin_oe      (pin_oe),
    .fb_out      (fb_out),
    .tick        (sel_tick),
    .q_hold      (q_hold)
);

// File: tb/mc_iocell_tb.sv
module mc_iocell_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_mode = 4'b1000;
    logic       cfg_clk_pterm = 1'b0;
    logic       cfg_clk_inv = 1'b0;
    logic       or_sum = 1'b0;
    logic       oe_term = 1'b0;
    logic       preset_term = 1'b0;
    logic       clear_term = 1'b0;
    logic       pin_clk = 1'b0;
    logic       pt_clk = 1'b0;
    logic       pin_in = 1'b0;
    logic       pin_out;
    logic       pin_oe;
    logic       fb_out;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    logic q_m = 1'b0;

    always #5 clk = ~clk;

    mc_iocell u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mode      (cfg_mode),
        .cfg_clk_pterm (cfg_clk_pterm),
        .cfg_clk_inv   (cfg_clk_inv),
        .or_sum        (or_sum),
        .oe_term       (oe_term),
        .preset_term   (preset_term),
        .clear_term    (clear_term),
        .pin_clk       (pin_clk),
        .pt_clk        (pt_clk),
        .pin_in        (pin_in),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe),
        .fb_out        (fb_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic is_legal(input logic [3:0] m);
        return m[1:0] != 2'b01;
    endfunction

    function automatic logic exp_out(input logic [3:0] m, input logic q, input logic s);
        logic v;
        case (m[2:0])
            3'b000, 3'b010, 3'b011: v = q;
            3'b100, 3'b110, 3'b111: v = s;
            default: return 1'b0;
        endcase
        return m[3] ? v : ~v;
    endfunction

    function automatic logic exp_fb(input logic [3:0] m, input logic q, input logic s, input logic p);
        case (m[2:0])
            3'b010, 3'b100: return p;
            3'b011, 3'b111: return s;
            3'b000, 3'b110: return q;
            default:        return p;
        endcase
    endfunction

    task automatic check_ports(input string tag);
        logic qv;
        #1;
        qv = clear_term ? 1'b0 : q_m;
        chk({tag, " oe"}, pin_oe, is_legal(cfg_mode) & oe_term);
        if (is_legal(cfg_mode))
            chk({tag, " out"}, pin_out, exp_out(cfg_mode, qv, or_sum));
        else
            chk({tag, " out"}, pin_out, 1'b0);
        chk({tag, " fb"}, fb_out, exp_fb(cfg_mode, qv, or_sum, pin_in));
    endtask

    // Active edge on the selected source; data inputs are held by the caller.
    task automatic active_edge();
        @(negedge clk);
        if (cfg_clk_pterm) pt_clk = ~cfg_clk_inv;
        else               pin_clk = ~cfg_clk_inv;
        @(negedge clk);
        if (clear_term)       q_m = 1'b0;
        else if (preset_term) q_m = 1'b1;
        else                  q_m = or_sum;
        pin_clk = cfg_clk_inv;
        pt_clk  = cfg_clk_inv;
    endtask

    task automatic sweep(input string tag);
        for (int m = 0; m < 16; m++) begin
            for (int v = 0; v < 8; v++) begin
                @(negedge clk);
                cfg_mode = m[3:0];
                or_sum   = v[0];
                pin_in   = v[1];
                oe_term  = v[2];
                check_ports(tag);
            end
        end
        @(negedge clk);
        cfg_mode = 4'b1000;
        oe_term  = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_ports("R1 reset");

        sweep("R8 R9 R10 R11 R12 sweep q0");

        // R2: capture on selected edge
        or_sum = 1'b1; active_edge(); check_ports("R2 load 1");
        or_sum = 1'b0; active_edge(); check_ports("R2 load 0");
        or_sum = 1'b1; active_edge(); check_ports("R2 load 1 again");
        or_sum = 1'b0; active_edge();

        // R5: preset beats data
        preset_term = 1'b1; active_edge(); check_ports("R5 preset");
        @(negedge clk); preset_term = 1'b0;

        sweep("R8 R9 R10 R11 R12 sweep q1");

        // R6: immediate clear, stays low after release
        @(negedge clk); clear_term = 1'b1; check_ports("R6 clear immediate");
        q_m = 1'b0;
        @(negedge clk); clear_term = 1'b0; check_ports("R6 clear held");

        // R7: clear over preset
        or_sum = 1'b1; active_edge(); check_ports("R7 setup");
        @(negedge clk); clear_term = 1'b1; preset_term = 1'b1; q_m = 1'b0;
        active_edge();
        clear_term = 1'b0; preset_term = 1'b0;
        check_ports("R7 clear wins");

        // R3: unselected clock ignored, then product-term clock used
        @(negedge clk); or_sum = 1'b1;
        pt_clk = 1'b1; @(negedge clk); pt_clk = 1'b0; @(negedge clk);
        check_ports("R3 pt clock ignored");
        cfg_clk_pterm = 1'b1;
        active_edge(); check_ports("R3 pt clock loads");
        @(negedge clk); or_sum = 1'b0;
        pin_clk = 1'b1; @(negedge clk); pin_clk = 1'b0; @(negedge clk);
        check_ports("R3 pin clock ignored");
        cfg_clk_pterm = 1'b0;

        // R4: inverted pin clock loads on falling source edge only
        @(negedge clk); cfg_clk_inv = 1'b1; pin_clk = 1'b1; pt_clk = 1'b1;
        @(negedge clk); or_sum = 1'b0; pin_clk = 1'b0;
        @(negedge clk); q_m = 1'b0; or_sum = 1'b1; pin_clk = 1'b1;
        @(negedge clk); check_ports("R4 rising source ignored");
        or_sum = 1'b1; active_edge(); check_ports("R4 falling source loads");
        cfg_mode = 4'b0000; check_ports("R4 R9 inverted output");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule